// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Burst Sequencer

This block is a single-port synchronous static memory that takes a new read or write command on every enabled clock edge. The data for each command moves one cycle after the command itself, so reads and writes can follow each other in any order with no idle cycle between them. A write supplies its address and lane enables in the command cycle and its data at the next enabled edge. The block keeps the address and lane enables in a small pipeline until that data arrives, then holds the complete write in a one-entry buffer that retires into the array at the following enabled edge. A read that targets a word still in flight is served from the pipeline, so it always returns the newest data.

A command either loads a fresh external address or advances an internal burst sequencer. The sequencer steps through a group of `BURST_LEN` words, in interleaved or linear order chosen by a parameter, and wraps back to the first word. An advance keeps the direction that was set when the burst was loaded. Three chip-select inputs gate new commands. A clock-enable input lets the system freeze the whole block for any number of cycles. The bidirectional data bus is split into a data-in port, a data-out port and an output-enable.

Top module: `latewr_sram`

## Requirements
- R1: A load cycle (`clk_en_n`=0, `adv_ld`=0) selects the chip only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. Any other combination of the three selects is a deselect.
- R2: A selected load with `rd_wr_n`=1 is a read at `addr`. After that edge, `rdata_oe` is 1 and `rdata` holds the word at `addr`.
- R3: A selected load with `rd_wr_n`=0 is a write at `addr`. The word on `wdata` at the next enabled edge is stored there.
- R4: An advance (`adv_ld`=1) inside an active burst accesses the next word of the burst and ignores `rd_wr_n`. With the default interleaved order, the k-th advance after a load at base B uses address bits [1:0] = B[1:0] XOR (k mod 4) and keeps every higher bit of B. The fourth advance returns to B.
- R5: Every access of a burst has the direction of its load. A write burst stores each advance's `wdata` at the following enabled edge, and a read burst drives each word.
- R6: After a deselect, `rdata_oe` is 0 following the edge. An advance issued while no burst is active is a no-operation and also leaves `rdata_oe` at 0.
- R7: An edge with `clk_en_n`=1 has no effect. `rdata`, `rdata_oe`, the burst state and any pending write are unchanged. The data phase of a pending write moves to the next enabled edge.
- R8: The word is split into four 9-bit lanes, with lane i at bits [9i+8:9i]. A write changes lane i only if `lane_we_n[i]`=0 in its command cycle. Any mix of lanes may be written, and `lane_we_n`=4'hF changes nothing.
- R9: While `rst_n` is 0 at a clock edge, `rdata_oe` is 0 after that edge. After reset it stays 0 until a read is issued.
- R10: A read of an address with an earlier write still pending returns the newly written lanes. This holds when the read comes in the next cycle or in the cycle after.
- R11: The edge that accepts a write command leaves `rdata_oe` at 0 for the write's data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the block |
| rd_wr_n | input | 1 | 1 = read, 0 = write; sampled on load cycles only |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b_n | input | 1 | Chip select, active low |
| sel_c | input | 1 | Chip select, active high |
| adv_ld | input | 1 | 0 = load external address, 1 = advance burst |
| lane_we_n | input | LANES | Per-lane write enables, active low, taken in the command cycle |
| addr | input | AW | Word address for load cycles |
| wdata | input | LANES*LANE_W | Write data, taken one enabled edge after its command |
| rdata | output | LANES*LANE_W | Read data for the command of the previous edge |
| rdata_oe | output | 1 | Drive enable for the data bus; 0 means high impedance |

## Verification
First, a full-depth sweep writes every address with a distinct pattern, back to back, and then reads each one back. This separates correct addressing and data alignment from any off-by-one-cycle error in the late-write pipeline. All eight chip-select combinations are then tried on load reads, and only the one select pattern must drive the bus. Bursts are started from each of the four low-bit offsets and advanced past the wrap. Because every word is unique, an error in the interleaved order shows up as a wrong data value. All sixteen lane masks are written over a known word, which isolates the lane gating. Read-after-write at distances one and two, and runs of suspended edges carrying junk commands and junk data, together show whether the bypass and the freeze each hold on their own.

// File: rtl/latewr_sram_pkg.sv
package latewr_sram_pkg;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_e;

   localparam int ORDER_INTERLEAVED = 0;
   localparam int ORDER_LINEAR      = 1;

endpackage

// File: rtl/lw_burst_addr.sv
module lw_burst_addr #(
   parameter int AW    = 10,
   parameter int BL_W  = 2,
   parameter int ORDER = 0
) (
   input  logic [AW-1:0]   base,
   input  logic [BL_W-1:0] step,
   output logic [AW-1:0]   addr
);

   logic [BL_W-1:0] low_bits;

   generate
      if (ORDER == latewr_sram_pkg::ORDER_LINEAR) begin : g_linear
         assign low_bits = base[BL_W-1:0] + step;
      end else begin : g_interleaved
         assign low_bits = base[BL_W-1:0] ^ step;
      end
   endgenerate

   assign addr = {base[AW-1:BL_W], low_bits};

endmodule

// File: rtl/lw_ctrl.sv
module lw_ctrl
   import latewr_sram_pkg::*;
#(
   parameter int AW    = 10,
   parameter int BL_W  = 2,
   parameter int ORDER = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          rd_wr_n,
   input  logic          sel_a_n,
   input  logic          sel_b_n,
   input  logic          sel_c,
   input  logic          adv_ld,
   input  logic [AW-1:0] ext_addr,
   output acc_e          acc_kind,
   output logic [AW-1:0] acc_addr
);

   logic            chip_sel;
   logic            run_q;
   logic            run_wr_q;
   logic [AW-1:0]   base_q;
   logic [BL_W-1:0] cnt_q;
   logic [BL_W-1:0] cnt_nxt;
   logic [AW-1:0]   seq_addr;

   assign chip_sel = !sel_a_n && !sel_b_n && sel_c;
   assign cnt_nxt  = cnt_q + 1'b1;

   lw_burst_addr #(
      .AW    (AW),
      .BL_W  (BL_W),
      .ORDER (ORDER)
   ) u_seq (
      .base (base_q),
      .step (cnt_nxt),
      .addr (seq_addr)
   );

   always_comb begin
      acc_kind = ACC_NONE;
      acc_addr = ext_addr;
      if (!adv_ld) begin
         if (chip_sel) begin
            acc_kind = rd_wr_n ? ACC_READ : ACC_WRITE;
         end
      end else if (run_q) begin
         acc_kind = run_wr_q ? ACC_WRITE : ACC_READ;
         acc_addr = seq_addr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         run_wr_q <= 1'b0;
         base_q   <= '0;
         cnt_q    <= '0;
      end else if (en) begin
         if (!adv_ld) begin
            run_q    <= chip_sel;
            run_wr_q <= !rd_wr_n;
            base_q   <= ext_addr;
            cnt_q    <= '0;
         end else if (run_q) begin
            cnt_q    <= cnt_nxt;
         end
      end
   end

   // R5: an advance never changes the burst direction
   p_burst_dir_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && adv_ld) |=> $stable(run_wr_q));

   // R4: an advance stays inside the aligned group of its base
   p_burst_upper_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && adv_ld && run_q) |-> (acc_addr[AW-1:BL_W] == base_q[AW-1:BL_W]));

   // R4: the advance after the last word wraps to the base address
   p_burst_wrap_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (adv_ld && run_q && (cnt_q == {BL_W{1'b1}})) |-> (acc_addr == base_q));

endmodule

// File: rtl/lw_lane_ram.sv
module lw_lane_ram #(
   parameter int DEPTH  = 1024,
   parameter int AW     = 10,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    wr_en,
   input  logic [AW-1:0]           wr_addr,
   input  logic [LANES-1:0]        wr_lanes,
   input  logic [LANES*LANE_W-1:0] wr_data,
   input  logic [AW-1:0]           rd_addr,
   output logic [LANES*LANE_W-1:0] rd_data
);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] mem [DEPTH];

         always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g]) begin
               mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
         end

         assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
      end
   endgenerate

endmodule

// File: rtl/latewr_sram.sv
module latewr_sram
   import latewr_sram_pkg::*;
#(
   parameter  int DEPTH       = 1024,
   parameter  int LANES       = 4,
   parameter  int LANE_W      = 9,
   parameter  int BURST_LEN   = 4,
   parameter  int BURST_ORDER = ORDER_INTERLEAVED,
   localparam int AW          = $clog2(DEPTH),
   localparam int BL_W        = $clog2(BURST_LEN),
   localparam int DW          = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en_n,
   input  logic             rd_wr_n,
   input  logic             sel_a_n,
   input  logic             sel_b_n,
   input  logic             sel_c,
   input  logic             adv_ld,
   input  logic [LANES-1:0] lane_we_n,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   output logic             rdata_oe
);

   initial begin
      assert (DEPTH == (1 << AW)) else $error("DEPTH must be a power of two");
      assert (BURST_LEN == (1 << BL_W) && BURST_LEN >= 2)
         else $error("BURST_LEN must be a power of two, at least 2");
      assert (BURST_LEN < DEPTH) else $error("BURST_LEN must be below DEPTH");
      assert (LANES >= 1 && LANE_W >= 1) else $error("lane shape must be non-empty");
      assert (BURST_ORDER == ORDER_INTERLEAVED || BURST_ORDER == ORDER_LINEAR)
         else $error("unknown BURST_ORDER");
   end

   logic             en;
   acc_e             acc_kind;
   logic [AW-1:0]    acc_addr;

   // command stage: write waiting for its data
   logic             s1_wr_q;
   logic [AW-1:0]    s1_addr_q;
   logic [LANES-1:0] s1_lanes_q;

   // write buffer: complete write waiting to retire into the array
   logic             wb_vld_q;
   logic [AW-1:0]    wb_addr_q;
   logic [LANES-1:0] wb_lanes_q;
   logic [DW-1:0]    wb_data_q;

   logic [DW-1:0]    arr_rd;
   logic [DW-1:0]    rd_merge;
   logic             wb_hit;
   logic             s1_hit;

   assign en = !clk_en_n;

   lw_ctrl #(
      .AW    (AW),
      .BL_W  (BL_W),
      .ORDER (BURST_ORDER)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .rd_wr_n  (rd_wr_n),
      .sel_a_n  (sel_a_n),
      .sel_b_n  (sel_b_n),
      .sel_c    (sel_c),
      .adv_ld   (adv_ld),
      .ext_addr (addr),
      .acc_kind (acc_kind),
      .acc_addr (acc_addr)
   );

   lw_lane_ram #(
      .DEPTH  (DEPTH),
      .AW     (AW),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_ram (
      .clk      (clk),
      .wr_en    (en && wb_vld_q),
      .wr_addr  (wb_addr_q),
      .wr_lanes (wb_lanes_q),
      .wr_data  (wb_data_q),
      .rd_addr  (acc_addr),
      .rd_data  (arr_rd)
   );

   assign wb_hit = wb_vld_q && (wb_addr_q == acc_addr);
   assign s1_hit = s1_wr_q  && (s1_addr_q == acc_addr);

   // newest data wins: array, then buffered write, then write on the bus now
   generate
      for (genvar g = 0; g < LANES; g++) begin : g_byp
         logic [LANE_W-1:0] lane_v;
         always_comb begin
            lane_v = arr_rd[g*LANE_W +: LANE_W];
            if (wb_hit && wb_lanes_q[g]) lane_v = wb_data_q[g*LANE_W +: LANE_W];
            if (s1_hit && s1_lanes_q[g]) lane_v = wdata[g*LANE_W +: LANE_W];
         end
         assign rd_merge[g*LANE_W +: LANE_W] = lane_v;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_wr_q    <= 1'b0;
         s1_addr_q  <= '0;
         s1_lanes_q <= '0;
         wb_vld_q   <= 1'b0;
         wb_addr_q  <= '0;
         wb_lanes_q <= '0;
         wb_data_q  <= '0;
         rdata      <= '0;
         rdata_oe   <= 1'b0;
      end else if (en) begin
         wb_vld_q   <= s1_wr_q;
         wb_addr_q  <= s1_addr_q;
         wb_lanes_q <= s1_lanes_q;
         wb_data_q  <= wdata;
         s1_wr_q    <= (acc_kind == ACC_WRITE);
         s1_addr_q  <= acc_addr;
         s1_lanes_q <= ~lane_we_n;
         rdata_oe   <= (acc_kind == ACC_READ);
         if (acc_kind == ACC_READ) begin
            rdata <= rd_merge;
         end
      end
   end

   // R2: a selected load read drives the bus in the next cycle
   p_read_drives_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && !adv_ld && rd_wr_n && !sel_a_n && !sel_b_n && sel_c) |=> rdata_oe);

   // R11: a selected load write keeps the bus released for its data cycle
   p_write_quiet_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && !adv_ld && !rd_wr_n && !sel_a_n && !sel_b_n && sel_c) |=> !rdata_oe);

   // R6: a deselect releases the bus one cycle later
   p_deselect_hiz_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && !adv_ld && (sel_a_n || sel_b_n || !sel_c)) |=> !rdata_oe);

   // R7: a suspended edge leaves the output side untouched
   p_suspend_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> ($stable(rdata) && $stable(rdata_oe)));

   // R7: a suspended edge does not retire the buffered write
   p_suspend_wb_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> ($stable(wb_vld_q) && $stable(wb_data_q)));

endmodule

// File: tb/latewr_sram_tb_top.sv
`timescale 1ns/1ps
module latewr_sram_tb_top;

   localparam int DEPTH = 1024;
   localparam int AW    = 10;
   localparam int DW    = 36;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          clk_en_n;
   logic          rd_wr_n;
   logic          sel_a_n;
   logic          sel_b_n;
   logic          sel_c;
   logic          adv_ld;
   logic [3:0]    lane_we_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata;
   logic [DW-1:0] rdata;
   logic          rdata_oe;

   always #5 clk = ~clk;

   latewr_sram dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_en_n  (clk_en_n),
      .rd_wr_n   (rd_wr_n),
      .sel_a_n   (sel_a_n),
      .sel_b_n   (sel_b_n),
      .sel_c     (sel_c),
      .adv_ld    (adv_ld),
      .lane_we_n (lane_we_n),
      .addr      (addr),
      .wdata     (wdata),
      .rdata     (rdata),
      .rdata_oe  (rdata_oe)
   );

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 1'b0;
   string tag     = "R9";

   // requirement-level model
   logic [DW-1:0] refmem [DEPTH];
   logic          m_run, m_wr;
   logic [AW-1:0] m_base;
   logic [1:0]    m_cnt;
   logic          p_wr;
   logic [AW-1:0] p_addr;
   logic [3:0]    p_lanes;
   logic          exp_oe;
   logic [DW-1:0] exp_rd;

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input logic [9:0] s);
      return {4'hA, a, a ^ s, 2'b01, ~a};
   endfunction

   function automatic logic [AW-1:0] burst_at(input logic [AW-1:0] b, input int k);
      logic [1:0] kk;
      kk = 2'(k);
      return {b[AW-1:2], b[1:0] ^ kk};
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic cen_n, input logic rw, input logic sa, input logic sb,
                      input logic sc, input logic adv, input logic [3:0] we_n,
                      input logic [AW-1:0] a, input logic [DW-1:0] wd);
      logic          sel;
      int            kind;
      logic [AW-1:0] ea;
      clk_en_n  = cen_n;  rd_wr_n = rw;  sel_a_n = sa;  sel_b_n = sb;  sel_c = sc;
      adv_ld    = adv;    lane_we_n = we_n;  addr = a;  wdata = wd;
      if (!cen_n) begin
         if (p_wr) begin
            for (int l = 0; l < 4; l++)
               if (p_lanes[l]) refmem[p_addr][l*9 +: 9] = wd[l*9 +: 9];
         end
         sel  = !sa && !sb && sc;
         kind = 0;
         ea   = a;
         if (!adv) begin
            if (sel) kind = rw ? 1 : 2;
            m_run = sel;  m_wr = !rw;  m_base = a;  m_cnt = 2'd0;
         end else if (m_run) begin
            m_cnt = m_cnt + 2'd1;
            ea    = {m_base[AW-1:2], m_base[1:0] ^ m_cnt};
            kind  = m_wr ? 2 : 1;
         end
         p_wr    = (kind == 2);
         p_addr  = ea;
         p_lanes = ~we_n;
         if (kind == 1) begin
            exp_oe = 1'b1;
            exp_rd = refmem[ea];
         end else begin
            exp_oe = 1'b0;
         end
      end
      @(posedge clk);
      @(negedge clk);
      chk({tag, " oe"}, {35'd0, rdata_oe}, {35'd0, exp_oe});
      if (exp_oe) chk({tag, " data"}, rdata, exp_rd);
   endtask

   task automatic ld(input logic rw, input logic [AW-1:0] a, input logic [3:0] we_n,
                     input logic [DW-1:0] wd);
      cyc(1'b0, rw, 1'b0, 1'b0, 1'b1, 1'b0, we_n, a, wd);
   endtask

   task automatic adv_c(input logic rw, input logic [3:0] we_n, input logic [DW-1:0] wd);
      cyc(1'b0, rw, 1'b0, 1'b0, 1'b1, 1'b1, we_n, 10'd0, wd);
   endtask

   task automatic nop(input logic [DW-1:0] wd);
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 10'd0, wd);
   endtask

   task automatic hold(input logic rw, input logic adv, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd);
      cyc(1'b1, rw, 1'b0, 1'b0, 1'b1, adv, 4'h0, a, wd);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      m_run = 0;  m_wr = 0;  m_base = '0;  m_cnt = '0;
      p_wr = 0;  p_addr = '0;  p_lanes = '0;  exp_oe = 0;  exp_rd = '0;
      rst_n = 1'b0;  clk_en_n = 1'b0;  rd_wr_n = 1'b1;  sel_a_n = 1'b0;
      sel_b_n = 1'b0;  sel_c = 1'b1;  adv_ld = 1'b0;  lane_we_n = 4'hF;
      addr = '0;  wdata = '0;
      // R9: reads presented during reset must not drive the bus
      repeat (4) begin
         @(negedge clk);
         addr = addr + 10'd1;
      end
      @(negedge clk);
      chk("R9 oe in reset", {35'd0, rdata_oe}, 36'd0);
      rst_n = 1'b1;
      nop('0);
      chk("R9 oe after reset", {35'd0, rdata_oe}, 36'd0);

      // R3: back-to-back writes of every address
      tag = "R3";
      for (int i = 0; i < DEPTH; i++)
         ld(1'b0, 10'(i), 4'h0, (i == 0) ? '0 : pat(10'(i - 1), 10'h155));
      nop(pat(10'(DEPTH - 1), 10'h155));

      // R2: back-to-back reads of every address
      tag = "R2";
      for (int i = 0; i < DEPTH; i++) ld(1'b1, 10'(i), 4'hF, '0);

      // R1: every chip-select combination on a load read
      tag = "R1";
      for (int c = 0; c < 8; c++) begin
         cyc(1'b0, 1'b1, c[2], c[1], c[0], 1'b0, 4'hF, 10'd5, '0);
         chk("R1 select decode", {35'd0, rdata_oe}, {35'd0, (c == 1)});
      end

      // R4: read bursts from each start offset, rd_wr_n low on advances, past the wrap
      tag = "R4";
      for (int b = 0; b < 4; b++) begin
         ld(1'b1, 10'(400 + b), 4'hF, '0);
         for (int k = 1; k <= 4; k++) begin
            adv_c(1'b0, 4'h0, '0);
            chk("R4 burst word", rdata, pat(burst_at(10'(400 + b), k), 10'h155));
         end
      end

      // R5: write burst with rd_wr_n high on advances, then read back by load
      tag = "R5";
      ld(1'b0, 10'd522, 4'h0, '0);
      for (int k = 1; k < 4; k++) adv_c(1'b1, 4'h0, pat(burst_at(10'd522, k - 1), 10'h2AA));
      nop(pat(burst_at(10'd522, 3), 10'h2AA));
      for (int k = 0; k < 4; k++) begin
         ld(1'b1, burst_at(10'd522, k), 4'hF, '0);
         chk("R5 burst write", rdata, pat(burst_at(10'd522, k), 10'h2AA));
      end

      // R8: every lane mask written over a known word
      tag = "R8";
      for (int m = 0; m < 16; m++) begin
         ld(1'b0, 10'(600 + m), 4'h0, '0);
         ld(1'b0, 10'(600 + m), ~4'(m), pat(10'(600 + m), 10'h0F0));
         nop(pat(10'(600 + m), 10'h30F) ^ 36'hF_FFFF_FFFF);
         ld(1'b1, 10'(600 + m), 4'hF, '0);
      end

      // R10: read right after, and two after, a pending write
      tag = "R10";
      ld(1'b0, 10'd700, 4'h0, '0);
      ld(1'b1, 10'd700, 4'hF, 36'h1_2345_6789);
      chk("R10 bypass distance 1", rdata, 36'h1_2345_6789);
      ld(1'b0, 10'd701, 4'h5, '0);
      nop(36'h9_8765_4321);
      ld(1'b1, 10'd701, 4'hF, '0);
      ld(1'b0, 10'd702, 4'h0, '0);
      ld(1'b1, 10'd10, 4'hF, 36'hA_BCDE_F012);
      ld(1'b1, 10'd702, 4'hF, '0);
      chk("R10 bypass distance 2", rdata, 36'hA_BCDE_F012);

      // R7: suspended edges with junk commands and junk data
      tag = "R7";
      ld(1'b1, 10'd11, 4'hF, '0);
      hold(1'b0, 1'b0, 10'd12, 36'hF_0F0F_0F0F);
      hold(1'b1, 1'b1, 10'd13, 36'h0_F0F0_F0F0);
      chk("R7 held data", rdata, pat(10'd11, 10'h155));
      ld(1'b0, 10'd20, 4'h0, '0);
      hold(1'b1, 1'b0, 10'd21, 36'h5_5555_5555);
      hold(1'b0, 1'b1, 10'd22, 36'hA_AAAA_AAAA);
      nop(36'h3_1415_9265);
      ld(1'b1, 10'd20, 4'hF, '0);
      chk("R7 delayed data phase", rdata, 36'h3_1415_9265);
      ld(1'b1, 10'd12, 4'hF, '0);

      // R6: deselect, then advance with no active burst
      tag = "R6";
      ld(1'b1, 10'd30, 4'hF, '0);
      nop('0);
      adv_c(1'b1, 4'hF, '0);
      chk("R6 idle advance", {35'd0, rdata_oe}, 36'd0);

      // R11: write right after a read releases the bus
      tag = "R11";
      ld(1'b1, 10'd40, 4'hF, '0);
      ld(1'b0, 10'd41, 4'h0, '0);
      chk("R11 write cycle oe", {35'd0, rdata_oe}, 36'd0);
      nop(36'h7_7777_7777);
      ld(1'b1, 10'd41, 4'hF, '0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule